// File: doc/BRIEF.md
# Over-Temperature Alarm Comparator with Hysteresis

This block watches the stream of temperature results coming out of a converter and decides whether the part is too hot. Each accepted result is a 16-bit two's-complement word. It is compared, as a signed number, against a programmable upper trip limit and a programmable lower release limit. Only the upper eleven bits of each limit take part in the comparison, so the limits move in quarter-degree steps. An alarm is raised when a result is strictly above the upper limit. It stays raised until a result falls strictly below the lower limit, which gives a hysteresis band between the two limits. Software can also drop the alarm with a write-one clear pulse. If the part is still hot, the alarm comes back with the next hot result.

Two sticky flags record that the upper or the lower limit has been crossed. A flag stays set until software reads the status register at a time when the condition behind it no longer holds. The alarm drives a pin whose active level is selectable, and a status bit. A disable control forces both the pin and the status bit to their inactive level without losing the internal alarm state. Results arrive on a valid/ready port. The block never applies back-pressure once it is out of reset. It holds ready low during reset and raises ready on the first clock edge after reset is released. From then on it takes one result on every edge where valid is high.

Top module: `ot_alarm_cmp`

## Requirements
- R1: `smp_ready` is 0 while `rst` is high and becomes 1 after the first rising edge with `rst` low. A result is taken on each rising edge where both `smp_valid` and `smp_ready` are 1.
- R2: A taken result that is signed-greater than the upper limit, with limit bits 4:0 treated as zero, sets the alarm. A result equal to the masked limit does not set it.
- R3: A taken result that is signed-less than the lower limit, with limit bits 4:0 treated as zero, clears the alarm.
- R4: A cycle with `alm_clr` high clears the alarm, unless a hot result is taken in the same cycle, in which case the alarm is set. An alarm cleared while the part is hot is set again by the next hot result.
- R5: A taken result that lies inside the band, or a cycle with no result and no clear, leaves the alarm unchanged.
- R6: `flag_hi` sets on every taken hot result. It clears only on a cycle with `stat_rd` high where the most recent taken result, including one taken in that cycle, is not hot.
- R7: `flag_lo` sets on every taken cold result. It clears only on a cycle with `stat_rd` high where the most recent taken result, including one taken in that cycle, is not cold.
- R8: With `alm_pol` = 1, `alm_pin` equals `alm_stat` (active-high). With `alm_pol` = 0, `alm_pin` is its inverse (active-low).
- R9: With `alm_dis` = 1, `alm_stat` is 0 and `alm_pin` sits at its inactive level. The internal alarm state is kept and shows again when `alm_dis` returns to 0.
- R10: Reset is synchronous and active-high. It clears the alarm and both flags, so with `alm_pol` = 0 the pin reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | A new conversion result is presented |
| smp_ready | output | 1 | The block accepts a result on this edge |
| smp_data | input | 16 | Conversion result, two's complement |
| lim_hi | input | 16 | Upper trip limit, bits 4:0 ignored |
| lim_lo | input | 16 | Lower release limit, bits 4:0 ignored |
| alm_dis | input | 1 | Forces pin and status bit inactive |
| alm_pol | input | 1 | 1 = active-high pin, 0 = active-low pin |
| alm_clr | input | 1 | Write-one pulse that clears the alarm |
| stat_rd | input | 1 | Pulse marking a read of the status register |
| alm_pin | output | 1 | Alarm pin level |
| alm_stat | output | 1 | Alarm status bit |
| flag_hi | output | 1 | Sticky upper-limit flag |
| flag_lo | output | 1 | Sticky lower-limit flag |

## Verification
The alarm, both flags and ready are registered, so their response to a result, a clear pulse or a status read appears after the edge that samples that stimulus, one cycle later. The pin and status bit follow `alm_dis` and `alm_pol` in the same cycle, with no register in between. The bench changes inputs just after each falling edge and samples every output at the next falling edge. At that point the registered outputs reflect exactly one rising edge and the combinational ones reflect the settled controls. The behavioural model advances on the same rising edge and is compared at that sampling point on every cycle.

// File: rtl/ot_pkg.sv
package ot_pkg;
  localparam int unsigned OT_SIDES = 2;
  localparam int unsigned SIDE_HI  = 0;
  localparam int unsigned SIDE_LO  = 1;

  typedef struct packed {
    logic hot;
    logic cold;
  } ot_cmp_t;
endpackage

// File: rtl/ot_limit_cmp.sv
module ot_limit_cmp
  import ot_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned CMP_LSB = 5
) (
  input  logic [W-1:0] smp,
  input  logic [W-1:0] lim_hi,
  input  logic [W-1:0] lim_lo,
  output ot_cmp_t      res
);
  localparam logic [W-1:0] KEEP = {{(W-CMP_LSB){1'b1}}, {CMP_LSB{1'b0}}};

  logic signed [W-1:0] s_smp, s_hi, s_lo;

  always_comb begin
    s_smp    = $signed(smp);
    s_hi     = $signed(lim_hi & KEEP);
    s_lo     = $signed(lim_lo & KEEP);
    res.hot  = s_smp > s_hi;
    res.cold = s_smp < s_lo;
  end
endmodule

// File: rtl/ot_alarm_core.sv
module ot_alarm_core (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic hot,
  input  logic cold,
  input  logic clr,
  output logic alarm_q
);
  always_ff @(posedge clk) begin
    if (rst)                 alarm_q <= 1'b0;
    else if (fire && hot)    alarm_q <= 1'b1;
    else if (fire && cold)   alarm_q <= 1'b0;
    else if (clr)            alarm_q <= 1'b0;
  end

  // R2, R4: a hot result always wins, even against a clear pulse
  a_r2_hot_sets: assert property (@(posedge clk) disable iff (rst)
    (fire && hot) |=> alarm_q);
  // R3
  a_r3_cold_clears: assert property (@(posedge clk) disable iff (rst)
    (fire && cold && !hot) |=> !alarm_q);
  // R4
  a_r4_clr_clears: assert property (@(posedge clk) disable iff (rst)
    (clr && !(fire && hot)) |=> !alarm_q);
  // R5
  a_r5_rise_needs_hot: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_q) |-> $past(fire && hot));
endmodule

// File: rtl/ot_sticky_flag.sv
module ot_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic cond,
  input  logic rd,
  output logic flag_q
);
  logic cond_q;
  logic cond_now;

  assign cond_now = fire ? cond : cond_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      cond_q <= cond_now;
      if (fire && cond)         flag_q <= 1'b1;
      else if (rd && !cond_now) flag_q <= 1'b0;
    end
  end

  // R6, R7: the flag only falls on a status read
  a_r6_fall_on_read: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q) |-> $past(rd));
  // R6, R7
  a_r7_set_on_cond: assert property (@(posedge clk) disable iff (rst)
    (fire && cond) |=> flag_q);
endmodule

// File: rtl/ot_alarm_cmp.sv
module ot_alarm_cmp
  import ot_pkg::*;
#(
  parameter int unsigned W       = 16,
  parameter int unsigned CMP_LSB = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_valid,
  output logic         smp_ready,
  input  logic [W-1:0] smp_data,
  input  logic [W-1:0] lim_hi,
  input  logic [W-1:0] lim_lo,
  input  logic         alm_dis,
  input  logic         alm_pol,
  input  logic         alm_clr,
  input  logic         stat_rd,
  output logic         alm_pin,
  output logic         alm_stat,
  output logic         flag_hi,
  output logic         flag_lo
);
  logic                fire;
  ot_cmp_t             cmp;
  logic                alarm_q;
  logic [OT_SIDES-1:0] side_cond;
  logic [OT_SIDES-1:0] side_flag;

  always_ff @(posedge clk) begin
    if (rst) smp_ready <= 1'b0;
    else     smp_ready <= 1'b1;
  end

  assign fire = smp_valid && smp_ready;

  ot_limit_cmp #(.W(W), .CMP_LSB(CMP_LSB)) u_cmp (
    .smp(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo), .res(cmp)
  );

  ot_alarm_core u_core (
    .clk(clk), .rst(rst), .fire(fire), .hot(cmp.hot), .cold(cmp.cold),
    .clr(alm_clr), .alarm_q(alarm_q)
  );

  assign side_cond[SIDE_HI] = cmp.hot;
  assign side_cond[SIDE_LO] = cmp.cold;

  for (genvar g = 0; g < OT_SIDES; g++) begin : g_flag
    ot_sticky_flag u_flag (
      .clk(clk), .rst(rst), .fire(fire), .cond(side_cond[g]),
      .rd(stat_rd), .flag_q(side_flag[g])
    );
  end

  assign flag_hi  = side_flag[SIDE_HI];
  assign flag_lo  = side_flag[SIDE_LO];
  assign alm_stat = alarm_q && !alm_dis;
  assign alm_pin  = alm_pol ? alm_stat : !alm_stat;

  // R1
  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (rst)
    !rst |=> smp_ready);
endmodule

// File: tb/sim_ot_alarm_cmp.sv
`timescale 1ns/1ps
module sim_ot_alarm_cmp;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = 16'h0;
  logic [15:0] lim_hi = 16'h4880;
  logic [15:0] lim_lo = 16'h4600;
  logic        alm_dis = 1'b0;
  logic        alm_pol = 1'b0;
  logic        alm_clr = 1'b0;
  logic        stat_rd = 1'b0;
  logic        alm_pin, alm_stat, flag_hi, flag_lo;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  ot_alarm_cmp u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .alm_dis(alm_dis), .alm_pol(alm_pol), .alm_clr(alm_clr),
    .stat_rd(stat_rd), .alm_pin(alm_pin), .alm_stat(alm_stat),
    .flag_hi(flag_hi), .flag_lo(flag_lo)
  );

  // behavioural reference model
  int m_rdy, m_alarm, m_fh, m_fl, m_lasthot, m_lastcold;

  function automatic int to_int(input logic [15:0] v);
    return (v[15]) ? int'(v) - 65536 : int'(v);
  endfunction

  function automatic int quarter(input logic [15:0] v);
    int x;
    x = to_int(v);
    return (x >>> 5) * 32;
  endfunction

  always @(posedge clk) begin
    int t;
    bit take, h, c;
    started <= 1'b1;
    if (rst) begin
      m_rdy = 0; m_alarm = 0; m_fh = 0; m_fl = 0; m_lasthot = 0; m_lastcold = 0;
    end else begin
      take = smp_valid && (m_rdy != 0);
      t = to_int(smp_data);
      h = take && (t > quarter(lim_hi));
      c = take && (t < quarter(lim_lo));
      if (take) begin m_lasthot = h; m_lastcold = c; end
      if (h) m_alarm = 1;
      else if (c) m_alarm = 0;
      else if (alm_clr) m_alarm = 0;
      if (h) m_fh = 1; else if (stat_rd && m_lasthot == 0) m_fh = 0;
      if (c) m_fl = 1; else if (stat_rd && m_lastcold == 0) m_fl = 0;
      m_rdy = 1;
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    bit st;
    cyc++;
    if (started && !done) begin
      st = (m_alarm != 0) && !alm_dis;
      chk("R1 model ready", smp_ready, m_rdy != 0);
      chk("R2/R3/R4/R5/R9 model alarm status", alm_stat, st);
      chk("R8 model pin", alm_pin, alm_pol ? st : !st);
      chk("R6 model flag_hi", flag_hi, m_fh != 0);
      chk("R7 model flag_lo", flag_lo, m_fl != 0);
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input logic v, input logic [15:0] d,
                      input logic clr, input logic rd);
    smp_valid = v; smp_data = d; alm_clr = clr; stat_rd = rd;
    @(negedge clk); #1;
    smp_valid = 0; alm_clr = 0; stat_rd = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk); #1;
    @(negedge clk); #1;
    // R10 reset state, R1 ready low in reset
    chk("R10 pin in reset", alm_pin, 1'b1);
    chk("R10 flag_hi in reset", flag_hi, 1'b0);
    chk("R1 ready in reset", smp_ready, 1'b0);
    rst = 0;
    step(0, 16'h0, 0, 0);
    chk("R1 ready after reset", smp_ready, 1'b1);
    lim_hi = 16'h489F;                       // masked to 4880h
    step(1, 16'h4880, 0, 0);
    chk("R2 equal is not hot", alm_stat, 1'b0);
    step(1, 16'h4890, 0, 0);
    chk("R2 above masked limit", alm_stat, 1'b1);
    chk("R8 active-low pin", alm_pin, 1'b0);
    chk("R6 flag_hi set", flag_hi, 1'b1);
    step(1, 16'h4700, 0, 0);
    chk("R5 in band holds", alm_stat, 1'b1);
    chk("R6 flag_hi held", flag_hi, 1'b1);
    step(0, 16'h0, 0, 1);
    chk("R6 flag_hi cleared by read", flag_hi, 1'b0);
    step(1, 16'h4900, 0, 0);
    step(0, 16'h0, 0, 1);
    chk("R6 read while hot keeps flag", flag_hi, 1'b1);
    step(0, 16'h0, 1, 0);
    chk("R4 clear pulse", alm_stat, 1'b0);
    step(1, 16'h4900, 0, 0);
    chk("R4 reasserts on hot", alm_stat, 1'b1);
    step(1, 16'h4900, 1, 0);
    chk("R4 hot wins over clear", alm_stat, 1'b1);
    alm_pol = 1;
    step(0, 16'h0, 0, 0);
    chk("R8 active-high pin", alm_pin, 1'b1);
    alm_dis = 1;
    step(0, 16'h0, 0, 0);
    chk("R9 disabled status", alm_stat, 1'b0);
    chk("R9 disabled pin", alm_pin, 1'b0);
    alm_dis = 0;
    step(0, 16'h0, 0, 0);
    chk("R9 state kept", alm_stat, 1'b1);
    step(1, 16'hEB00, 0, 0);
    chk("R3 signed cold clears", alm_stat, 1'b0);
    chk("R7 flag_lo set", flag_lo, 1'b1);
    step(0, 16'h0, 0, 1);
    chk("R7 read while cold keeps", flag_lo, 1'b1);
    step(1, 16'h4700, 0, 0);
    step(0, 16'h0, 0, 1);
    chk("R7 flag_lo cleared", flag_lo, 1'b0);
    // mixed traffic, checked by the model every cycle
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      alm_pol = lfsr[9];
      alm_dis = (lfsr[7:5] == 3'b000);
      if (i % 150 == 0) begin lim_hi = 16'h4880 ^ lfsr[4:0]; lim_lo = 16'h4600 | lfsr[4:0]; end
      step(lfsr[0], {2'b01, lfsr[3], 3'b001, lfsr[15:6]}, lfsr[1] & lfsr[2], lfsr[4]);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule